// File: doc/BRIEF.md
# Endpoint FIFO Service Sequencer

This block is the master side of a peripheral controller's slave FIFO port. It owns the FIFO address select, the read and write strobes and the output enable. It watches one empty flag for each of the two receive endpoints and one full flag for each of the two transmit endpoints. The block visits the endpoints in a fixed loop:

1. It drains the main receive endpoint until a word count given by local logic runs out.
2. It writes the main reply.
3. It waits a fixed quiet interval.
4. It drains the auxiliary receive endpoint if anything is there.
5. It writes pending auxiliary transmit data if there is any.
6. It returns to waiting on the main receive endpoint.

Received words leave on two valid/ready streams. Words to transmit come in on two valid/ready streams that each carry a last marker. On every stream, valid never depends on ready, and a word moves only in a cycle where both are high. When a receive stream holds ready low, no read strobe is issued, so the FIFO keeps the word. When a transmit FIFO is full, ready stays low, so the source keeps its word until the flag clears. The FIFO data bus is treated as first-word-fall-through: the word at the head of the selected FIFO is valid while the block enables output.

Top module: `ep_svc_seq`

## Requirements
- R1: A synchronous reset leaves the select at 00, all strobes and the output enable low, and the block waiting on the main receive endpoint.
- R2: Select codes are 00 main receive, 01 auxiliary receive, 10 main transmit, 11 auxiliary transmit. A read or write strobe is only issued when the select has held the same value in the previous cycle, and read and write are never high together.
- R3: Once the main receive FIFO is not empty, the block latches `xfer_words` and reads exactly that many words from code 00, in FIFO order, onto the main receive stream. Reads happen only with the output enable high and the FIFO not empty.
- R4: If the main receive FIFO runs empty before the count reaches zero, the block stalls on code 00 with no reply writes, and resumes reading when words arrive.
- R5: After the count reaches zero, the reply stream is written to code 10 up to and including its last word. A write strobe is issued only while that FIFO's full flag is low. A word offered while full is held and written once full clears.
- R6: After the last reply write, exactly `GAP_CYCLES` cycles pass with no strobe, and then the select moves to 01.
- R7: On code 01, the auxiliary receive FIFO is read until empty onto the auxiliary receive stream. If it is empty at the check, it is skipped.
- R8: If the auxiliary transmit stream is valid at its check, its words are written to code 11 up to and including the last word, obeying that FIFO's full flag. Otherwise the step is skipped.
- R9: The loop then returns to select 00 and issues no read until the main receive FIFO is not empty.
- R10: A receive stream holding ready low prevents the read strobe for that word, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_sel | output | 2 | Endpoint FIFO select |
| fifo_oe | output | 1 | FIFO output enable (read phases) |
| fifo_rd | output | 1 | Read strobe, pops the selected FIFO |
| fifo_wr | output | 1 | Write strobe, pushes into the selected FIFO |
| fifo_rdata | input | W | Head word of the selected receive FIFO |
| fifo_wdata | output | W | Word being written |
| main_out_empty | input | 1 | Main receive FIFO empty |
| aux_out_empty | input | 1 | Auxiliary receive FIFO empty |
| main_in_full | input | 1 | Main transmit FIFO full |
| aux_in_full | input | 1 | Auxiliary transmit FIFO full |
| xfer_words | input | CW | Word count of the next main receive transfer |
| main_rx_valid | output | 1 | Main receive stream valid |
| main_rx_data | output | W | Main receive stream data |
| main_rx_ready | input | 1 | Main receive stream ready |
| aux_rx_valid | output | 1 | Auxiliary receive stream valid |
| aux_rx_data | output | W | Auxiliary receive stream data |
| aux_rx_ready | input | 1 | Auxiliary receive stream ready |
| reply_valid | input | 1 | Reply stream valid |
| reply_data | input | W | Reply stream data |
| reply_last | input | 1 | Reply stream final word |
| reply_ready | output | 1 | Reply stream ready |
| aux_tx_valid | input | 1 | Auxiliary transmit stream valid |
| aux_tx_data | input | W | Auxiliary transmit stream data |
| aux_tx_last | input | 1 | Auxiliary transmit final word |
| aux_tx_ready | output | 1 | Auxiliary transmit stream ready |

## Verification
Strobes and stream handshakes are combinational in the same cycle as the flags and readies that allow them. The FIFO effect therefore lands at the closing clock edge, and the bench models the FIFOs and streams as registers updated on that edge.

The select changes one edge before any strobe on the new endpoint. The select reaches 01 exactly `GAP_CYCLES + 1` edges after the edge that ends the last reply write, and the bench measures that distance in cycle counts rather than by waiting. Word counts and data are compared only after the select has been seen returning to 00, which happens one edge after the loop's final write. Stall and full-flag cases are sampled tens of cycles into the hold, well clear of any edge.

// File: rtl/ep_svc_pkg.sv
package ep_svc_pkg;

  // Endpoint select encoding driven onto the FIFO address pins.
  typedef enum logic [1:0] {
    EP_MAIN_OUT = 2'b00,
    EP_AUX_OUT  = 2'b01,
    EP_MAIN_IN  = 2'b10,
    EP_AUX_IN   = 2'b11
  } ep_sel_e;

  // Service loop states.
  typedef enum logic [3:0] {
    ST_WAIT_MAIN,
    ST_MAIN_RD,
    ST_REP_SET,
    ST_REP_WR,
    ST_GAP,
    ST_AUX_CHK,
    ST_AUX_RD,
    ST_ATX_CHK,
    ST_ATX_WR
  } svc_state_e;

endpackage

// File: rtl/ep_svc_gap_timer.sv
// One-shot interval timer: done is high in the last of GAP_CYCLES cycles
// counted from the cycle after start.
module ep_svc_gap_timer #(
  parameter int unsigned GAP_CYCLES = 1650
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int unsigned TW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [TW-1:0] LOAD = TW'(GAP_CYCLES - 1);

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/ep_svc_word_ctr.sv
// Remaining-word counter for the main receive transfer.
module ep_svc_word_ctr #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ep_svc_fsm.sv
// Service loop controller: select register, strobes and stream handshakes.
module ep_svc_fsm
  import ep_svc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  // FIFO flags
  input  logic       main_out_empty,
  input  logic       aux_out_empty,
  input  logic       main_in_full,
  input  logic       aux_in_full,
  // stream side
  input  logic       main_rx_ready,
  input  logic       aux_rx_ready,
  input  logic       reply_valid,
  input  logic       reply_last,
  input  logic       aux_tx_valid,
  input  logic       aux_tx_last,
  // helpers
  input  logic       gap_done,
  input  logic       cnt_zero,
  output logic       gap_start,
  output logic       cnt_load,
  output logic       cnt_dec,
  // FIFO port
  output logic [1:0] sel,
  output logic       oe,
  output logic       rd,
  output logic       wr,
  output logic       tx_from_aux,
  // stream handshakes
  output logic       main_rx_valid,
  output logic       aux_rx_valid,
  output logic       reply_ready,
  output logic       aux_tx_ready
);
  svc_state_e st_q, st_d;
  ep_sel_e    sel_q, sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_WAIT_MAIN;
      sel_q <= EP_MAIN_OUT;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    st_d          = st_q;
    sel_d         = sel_q;
    oe            = 1'b0;
    rd            = 1'b0;
    wr            = 1'b0;
    main_rx_valid = 1'b0;
    aux_rx_valid  = 1'b0;
    reply_ready   = 1'b0;
    aux_tx_ready  = 1'b0;
    gap_start     = 1'b0;
    cnt_load      = 1'b0;
    cnt_dec       = 1'b0;
    unique case (st_q)
      ST_WAIT_MAIN: begin
        // Select already points at the main receive FIFO; latch the count.
        if (!main_out_empty) begin
          cnt_load = 1'b1;
          st_d     = ST_MAIN_RD;
        end
      end
      ST_MAIN_RD: begin
        oe = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_REP_SET;
          sel_d = EP_MAIN_IN;
        end else begin
          main_rx_valid = !main_out_empty;
          rd            = main_rx_valid && main_rx_ready;
          cnt_dec       = rd;
        end
      end
      ST_REP_SET: st_d = ST_REP_WR;        // select settles for one cycle
      ST_REP_WR: begin
        reply_ready = !main_in_full;
        wr          = reply_valid && !main_in_full;
        if (wr && reply_last) begin
          gap_start = 1'b1;
          st_d      = ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          st_d  = ST_AUX_CHK;
          sel_d = EP_AUX_OUT;
        end
      end
      ST_AUX_CHK: begin
        if (aux_out_empty) begin
          st_d  = ST_ATX_CHK;
          sel_d = EP_AUX_IN;
        end else begin
          st_d  = ST_AUX_RD;
        end
      end
      ST_AUX_RD: begin
        oe = 1'b1;
        if (aux_out_empty) begin
          st_d  = ST_ATX_CHK;
          sel_d = EP_AUX_IN;
        end else begin
          aux_rx_valid = 1'b1;
          rd           = aux_rx_ready;
        end
      end
      ST_ATX_CHK: begin
        if (aux_tx_valid) begin
          st_d  = ST_ATX_WR;
        end else begin
          st_d  = ST_WAIT_MAIN;
          sel_d = EP_MAIN_OUT;
        end
      end
      ST_ATX_WR: begin
        aux_tx_ready = !aux_in_full;
        wr           = aux_tx_valid && !aux_in_full;
        if (wr && aux_tx_last) begin
          st_d  = ST_WAIT_MAIN;
          sel_d = EP_MAIN_OUT;
        end
      end
      default: begin
        st_d  = ST_WAIT_MAIN;
        sel_d = EP_MAIN_OUT;
      end
    endcase
  end

  assign sel         = sel_q;
  assign tx_from_aux = (st_q == ST_ATX_WR);
endmodule

// File: rtl/ep_svc_seq.sv
// Endpoint FIFO service sequencer, top level.
module ep_svc_seq #(
  parameter int unsigned W          = 16,
  parameter int unsigned CW         = 12,
  parameter int unsigned GAP_CYCLES = 1650
) (
  input  logic          clk,
  input  logic          rst,
  output logic [1:0]    fifo_sel,
  output logic          fifo_oe,
  output logic          fifo_rd,
  output logic          fifo_wr,
  input  logic [W-1:0]  fifo_rdata,
  output logic [W-1:0]  fifo_wdata,
  input  logic          main_out_empty,
  input  logic          aux_out_empty,
  input  logic          main_in_full,
  input  logic          aux_in_full,
  input  logic [CW-1:0] xfer_words,
  output logic          main_rx_valid,
  output logic [W-1:0]  main_rx_data,
  input  logic          main_rx_ready,
  output logic          aux_rx_valid,
  output logic [W-1:0]  aux_rx_data,
  input  logic          aux_rx_ready,
  input  logic          reply_valid,
  input  logic [W-1:0]  reply_data,
  input  logic          reply_last,
  output logic          reply_ready,
  input  logic          aux_tx_valid,
  input  logic [W-1:0]  aux_tx_data,
  input  logic          aux_tx_last,
  output logic          aux_tx_ready
);
  logic gap_start, gap_done;
  logic cnt_load, cnt_dec, cnt_zero;
  logic tx_from_aux;

  ep_svc_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .main_out_empty (main_out_empty),
    .aux_out_empty  (aux_out_empty),
    .main_in_full   (main_in_full),
    .aux_in_full    (aux_in_full),
    .main_rx_ready  (main_rx_ready),
    .aux_rx_ready   (aux_rx_ready),
    .reply_valid    (reply_valid),
    .reply_last     (reply_last),
    .aux_tx_valid   (aux_tx_valid),
    .aux_tx_last    (aux_tx_last),
    .gap_done       (gap_done),
    .cnt_zero       (cnt_zero),
    .gap_start      (gap_start),
    .cnt_load       (cnt_load),
    .cnt_dec        (cnt_dec),
    .sel            (fifo_sel),
    .oe             (fifo_oe),
    .rd             (fifo_rd),
    .wr             (fifo_wr),
    .tx_from_aux    (tx_from_aux),
    .main_rx_valid  (main_rx_valid),
    .aux_rx_valid   (aux_rx_valid),
    .reply_ready    (reply_ready),
    .aux_tx_ready   (aux_tx_ready)
  );

  ep_svc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .start (gap_start),
    .done  (gap_done)
  );

  ep_svc_word_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (xfer_words),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  // Head-of-FIFO word feeds both receive streams; valid picks the owner.
  assign main_rx_data = fifo_rdata;
  assign aux_rx_data  = fifo_rdata;
  assign fifo_wdata   = tx_from_aux ? aux_tx_data : reply_data;
endmodule

// File: rtl/ep_svc_seq_chk.sv
module ep_svc_seq_chk #(
  parameter int unsigned GAP_CYCLES = 1650
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] fifo_sel,
  input logic       fifo_rd,
  input logic       fifo_wr,
  input logic       fifo_oe,
  input logic       main_out_empty,
  input logic       aux_out_empty,
  input logic       main_in_full,
  input logic       aux_in_full,
  input logic       main_rx_ready,
  input logic       aux_rx_ready
);
  // Cycles since the last main transmit write, saturating.
  logic [31:0] since_rep;
  always_ff @(posedge clk) begin
    if (rst)                                   since_rep <= '1;
    else if (fifo_wr && fifo_sel == 2'b10)     since_rep <= '0;
    else if (since_rep != '1)                  since_rep <= since_rep + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fifo_sel == 2'b00 && !fifo_rd && !fifo_wr && !fifo_oe));

  p_sel_settled_r2: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd || fifo_wr) |-> fifo_sel == $past(fifo_sel));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(fifo_rd && fifo_wr));

  p_rd_legal_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (!fifo_sel[1] && fifo_oe &&
                 !(fifo_sel == 2'b00 ? main_out_empty : aux_out_empty)));

  p_wr_not_full_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (fifo_sel[1] && !fifo_oe &&
                 !(fifo_sel == 2'b10 ? main_in_full : aux_in_full)));

  p_gap_len_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_sel == 2'b01 && $past(fifo_sel) == 2'b10) |-> since_rep == GAP_CYCLES);

  p_gap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((fifo_rd || fifo_wr) && fifo_sel != 2'b10) |-> since_rep >= GAP_CYCLES);

  p_rd_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (fifo_sel == 2'b00 ? main_rx_ready : aux_rx_ready));
endmodule

bind ep_svc_seq ep_svc_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fifo_sel       (fifo_sel),
  .fifo_rd        (fifo_rd),
  .fifo_wr        (fifo_wr),
  .fifo_oe        (fifo_oe),
  .main_out_empty (main_out_empty),
  .aux_out_empty  (aux_out_empty),
  .main_in_full   (main_in_full),
  .aux_in_full    (aux_in_full),
  .main_rx_ready  (main_rx_ready),
  .aux_rx_ready   (aux_rx_ready)
);

// File: tb/ep_svc_seq_tb_top.sv
`timescale 1ns/1ps
module ep_svc_seq_tb_top;
  localparam int GAP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fifo_sel;
  logic        fifo_oe, fifo_rd, fifo_wr;
  logic [15:0] fifo_rdata, fifo_wdata;
  logic        main_out_empty, aux_out_empty, main_in_full, aux_in_full;
  logic [11:0] xfer_words = '0;
  logic        main_rx_valid, aux_rx_valid, main_rx_ready, aux_rx_ready;
  logic [15:0] main_rx_data, aux_rx_data;
  logic        reply_valid, reply_last, reply_ready;
  logic [15:0] reply_data;
  logic        aux_tx_valid, aux_tx_last, aux_tx_ready;
  logic [15:0] aux_tx_data;

  always #5 clk = ~clk;

  // Bench-side FIFO and stream models; counters are cumulative.
  logic [15:0] mo_mem [256];
  logic [15:0] ao_mem [256];
  logic [15:0] mrx_mem [256];
  logic [15:0] arx_mem [256];
  logic [15:0] mi_mem [256];
  logic [15:0] ai_mem [256];
  int mo_wp = 0, mo_rp = 0, ao_wp = 0, ao_rp = 0;
  int mrx_n = 0, arx_n = 0, mi_n = 0, ai_n = 0;
  int mi_drain = 0, mi_cap = 255;
  int rep_end = 0, rep_idx = 0, atx_end = 0, atx_idx = 0;
  int cyc = 0, last_rep = 0, gap_meas = -1, rounds = 0;
  logic [1:0] prev_sel = 2'b00;
  bit bp_mode = 1'b0;
  int errors = 0, checks = 0;

  assign main_out_empty = (mo_wp == mo_rp);
  assign aux_out_empty  = (ao_wp == ao_rp);
  assign main_in_full   = (mi_n - mi_drain) >= mi_cap;
  assign aux_in_full    = 1'b0;
  assign fifo_rdata     = (fifo_sel == 2'b01) ? ao_mem[ao_rp[7:0]] : mo_mem[mo_rp[7:0]];
  assign main_rx_ready  = bp_mode ? cyc[0] : 1'b1;
  assign aux_rx_ready   = bp_mode ? ~cyc[0] : 1'b1;
  assign reply_valid    = (rep_idx != rep_end);
  assign reply_last     = (rep_idx == rep_end - 1);
  assign reply_data     = 16'(32'hA000 + rep_idx);
  assign aux_tx_valid   = (atx_idx != atx_end);
  assign aux_tx_last    = (atx_idx == atx_end - 1);
  assign aux_tx_data    = 16'(32'h4000 + atx_idx);

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    prev_sel <= fifo_sel;
    if (fifo_rd && fifo_sel == 2'b00) mo_rp <= mo_rp + 1;
    if (fifo_rd && fifo_sel == 2'b01) ao_rp <= ao_rp + 1;
    if (main_rx_valid && main_rx_ready) begin
      mrx_mem[mrx_n[7:0]] <= main_rx_data; mrx_n <= mrx_n + 1;
    end
    if (aux_rx_valid && aux_rx_ready) begin
      arx_mem[arx_n[7:0]] <= aux_rx_data; arx_n <= arx_n + 1;
    end
    if (fifo_wr && fifo_sel == 2'b10) begin
      mi_mem[mi_n[7:0]] <= fifo_wdata; mi_n <= mi_n + 1; last_rep <= cyc;
    end
    if (fifo_wr && fifo_sel == 2'b11) begin
      ai_mem[ai_n[7:0]] <= fifo_wdata; ai_n <= ai_n + 1;
    end
    if (reply_valid && reply_ready)   rep_idx <= rep_idx + 1;
    if (aux_tx_valid && aux_tx_ready) atx_idx <= atx_idx + 1;
    if (fifo_sel == 2'b01 && prev_sel != 2'b01) gap_meas <= cyc - last_rep;
    if (fifo_sel == 2'b00 && prev_sel != 2'b00) rounds <= rounds + 1;
  end

  ep_svc_seq #(.W(16), .CW(12), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst(rst), .fifo_sel(fifo_sel), .fifo_oe(fifo_oe),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_rdata(fifo_rdata),
    .fifo_wdata(fifo_wdata), .main_out_empty(main_out_empty),
    .aux_out_empty(aux_out_empty), .main_in_full(main_in_full),
    .aux_in_full(aux_in_full), .xfer_words(xfer_words),
    .main_rx_valid(main_rx_valid), .main_rx_data(main_rx_data),
    .main_rx_ready(main_rx_ready), .aux_rx_valid(aux_rx_valid),
    .aux_rx_data(aux_rx_data), .aux_rx_ready(aux_rx_ready),
    .reply_valid(reply_valid), .reply_data(reply_data),
    .reply_last(reply_last), .reply_ready(reply_ready),
    .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
    .aux_tx_last(aux_tx_last), .aux_tx_ready(aux_tx_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_main(input int n);
    @(negedge clk);
    for (int k = 0; k < n; k++) mo_mem[(mo_wp + k) % 256] = 16'(32'h1000 + mo_wp + k);
    mo_wp = mo_wp + n;
  endtask

  task automatic stage(input int ml, input int rl, input int ao, input int ai);
    @(negedge clk);
    rep_end = rep_end + rl;
    atx_end = atx_end + ai;
    for (int k = 0; k < ao; k++) ao_mem[(ao_wp + k) % 256] = 16'(32'h3000 + ao_wp + k);
    ao_wp = ao_wp + ao;
    xfer_words = 12'(ml);
  endtask

  task automatic wait_round();
    int r0 = rounds;
    int t = 0;
    while (rounds == r0 && t < 3000) begin @(negedge clk); t++; end
    if (rounds == r0) chk(1'b0, "R9 loop did not return to 00", t, 0);
    repeat (2) @(negedge clk);
  endtask

  // Compare words [from, to) of a capture array with base + index.
  function automatic int bad_words(input logic [15:0] mem [256], input int from,
                                   input int to, input int base);
    int bad = 0;
    for (int i = from; i < to; i++) if (mem[i % 256] !== 16'(base + i)) bad++;
    return bad;
  endfunction

  // Vectors: {words, reply, aux rx, aux tx, backpressure} in bytes.
  localparam logic [39:0] VEC [5] = '{
    {8'd4, 8'd3, 8'd0, 8'd0, 8'd0},
    {8'd6, 8'd2, 8'd2, 8'd1, 8'd0},
    {8'd1, 8'd1, 8'd3, 8'd0, 8'd1},
    {8'd5, 8'd4, 8'd0, 8'd3, 8'd1},
    {8'd8, 8'd1, 8'd1, 8'd2, 8'd0}
  };

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s_mrx, s_mi, s_arx, s_ai, s_rep;
    // R1: reset state, during and just after reset.
    repeat (3) @(negedge clk);
    chk(fifo_sel == 2'b00 && !fifo_rd && !fifo_wr && !fifo_oe, "R1 idle in reset",
        {fifo_sel, fifo_rd, fifo_wr, fifo_oe}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(fifo_sel == 2'b00 && !fifo_rd && !fifo_oe, "R1 idle after reset",
        {fifo_sel, fifo_rd, fifo_oe}, 0);

    for (int v = 0; v < 5; v++) begin
      int ml = int'(VEC[v][39:32]);
      int rl = int'(VEC[v][31:24]);
      int ao = int'(VEC[v][23:16]);
      int ai = int'(VEC[v][15:8]);
      s_mrx = mrx_n; s_mi = mi_n; s_arx = arx_n; s_ai = ai_n;
      bp_mode = VEC[v][0];
      stage(ml, rl, ao, ai);
      push_main(ml);
      wait_round();
      chk(mrx_n - s_mrx == ml, bp_mode ? "R10 main words under backpressure" : "R3 main words",
          mrx_n - s_mrx, ml);
      chk(bad_words(mrx_mem, s_mrx, mrx_n, 32'h1000) == 0, "R3 main data order",
          bad_words(mrx_mem, s_mrx, mrx_n, 32'h1000), 0);
      chk(mi_n - s_mi == rl, "R5 reply words", mi_n - s_mi, rl);
      chk(bad_words(mi_mem, s_mi, mi_n, 32'hA000) == 0, "R5 reply data",
          bad_words(mi_mem, s_mi, mi_n, 32'hA000), 0);
      chk(gap_meas == GAP + 1, "R6 gap cycles", gap_meas, GAP + 1);
      chk(arx_n - s_arx == ao, bp_mode ? "R10 aux words under backpressure" : "R7 aux rx words",
          arx_n - s_arx, ao);
      chk(bad_words(arx_mem, s_arx, arx_n, 32'h3000) == 0, "R7 aux rx data",
          bad_words(arx_mem, s_arx, arx_n, 32'h3000), 0);
      chk(ai_n - s_ai == ai, "R8 aux tx words", ai_n - s_ai, ai);
      chk(bad_words(ai_mem, s_ai, ai_n, 32'h4000) == 0, "R8 aux tx data",
          bad_words(ai_mem, s_ai, ai_n, 32'h4000), 0);
      chk(fifo_sel == 2'b00, "R9 back on main receive", fifo_sel, 0);
    end
    bp_mode = 1'b0;

    // R9: idle with an empty main FIFO issues no reads.
    s_mrx = mrx_n;
    repeat (20) @(negedge clk);
    chk(mrx_n == s_mrx && fifo_sel == 2'b00 && !fifo_rd, "R9 no read while empty",
        mrx_n - s_mrx, 0);

    // R4: main FIFO runs dry halfway through the transfer.
    s_mrx = mrx_n; s_mi = mi_n;
    stage(4, 2, 0, 0);
    push_main(2);
    repeat (30) @(negedge clk);
    chk(mrx_n - s_mrx == 2, "R4 stalled word count", mrx_n - s_mrx, 2);
    chk(fifo_sel == 2'b00 && mi_n == s_mi, "R4 no reply during stall", mi_n - s_mi, 0);
    push_main(2);
    wait_round();
    chk(mrx_n - s_mrx == 4 && bad_words(mrx_mem, s_mrx, mrx_n, 32'h1000) == 0,
        "R4 resumed transfer", mrx_n - s_mrx, 4);
    chk(mi_n - s_mi == 2, "R4 reply after resume", mi_n - s_mi, 2);

    // R5: transmit FIFO fills after one reply word; word is held.
    @(negedge clk);
    mi_drain = mi_n; mi_cap = 1;
    s_mi = mi_n; s_rep = rep_idx;
    stage(2, 3, 0, 0);
    push_main(2);
    repeat (30) @(negedge clk);
    chk(mi_n - s_mi == 1, "R5 one word before full", mi_n - s_mi, 1);
    chk(rep_idx - s_rep == 1 && !reply_ready, "R5 word held while full", rep_idx - s_rep, 1);
    chk(fifo_sel == 2'b10, "R2 select on main transmit while held", fifo_sel, 2);
    mi_drain = mi_n; mi_cap = 255;
    wait_round();
    chk(mi_n - s_mi == 3 && bad_words(mi_mem, s_mi, mi_n, 32'hA000) == 0,
        "R5 reply complete after full clears", mi_n - s_mi, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule